// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Load Forwarding

This block sits between one core's memory port and a shared memory. Every store the core issues is held in a small first-in first-out queue of address/data pairs. The queue drains to memory one entry at a time, oldest first, through a valid/ready write channel. The memory side decides when each commit happens, and the core's later traffic has no effect on that timing.

A load first searches all pending stores. If any of them targets the load address, the data of the most recently queued matching store is returned and memory is not read. Otherwise the load reads memory through a combinational read port. A fence request is acknowledged only once the queue is empty, so the core stalls until every earlier store has reached memory. An occupancy count and an empty flag are visible at the ports.

Top module: `tso_store_buffer`

## Requirements
- R1: While rst_ni is low, and right after it is released, count_o is 0, empty_o is 1, cmt_valid_o is 0 and st_ready_o is 1. The reset is asynchronous and takes effect without waiting for a clock edge.
- R2: A store accepted in a cycle (st_valid_i and st_ready_o both high) never reaches the commit port in that same cycle. When the queue was empty, cmt_valid_o rises in the following cycle.
- R3: The commit port always presents the oldest pending entry on cmt_addr_o/cmt_data_o. Entries leave in the order they were accepted, one for each cycle in which cmt_valid_o and cmt_ready_i are both high.
- R4: st_ready_o is low exactly when DEPTH entries are pending. A store offered while it is low is dropped and leaves the contents unchanged.
- R5: count_o equals the number of pending entries. It goes up by one for an accepted store, down by one for a completed commit, and stays the same when both happen in one cycle. empty_o is 1 exactly when count_o is 0.
- R6: A load (ld_valid_i high) whose address matches one or more pending entries returns, in the same cycle, the data of the youngest matching entry on ld_data_o, with ld_hit_o high.
- R7: A load with no matching pending entry returns mem_rdata_i, which is the word at mem_raddr_o = ld_addr_i, with mem_re_o high. A forwarded load keeps mem_re_o low.
- R8: A load that arrives in the same cycle as the commit of the only entry matching its address still returns that entry's data.
- R9: fence_done_o is high in a cycle exactly when fence_i is high and the queue is empty.
- R10: While cmt_valid_o is high and cmt_ready_i is low, cmt_valid_o, cmt_addr_o and cmt_data_o stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Core offers a store |
| st_ready_o | output | 1 | Queue can accept a store |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| ld_valid_i | input | 1 | Core issues a load |
| ld_addr_i | input | ADDR_W | Load address |
| ld_data_o | output | DATA_W | Load result (same cycle) |
| ld_hit_o | output | 1 | Load was served from the queue |
| mem_re_o | output | 1 | Memory read needed for this load |
| mem_raddr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data (combinational) |
| cmt_valid_o | output | 1 | Oldest entry offered to memory |
| cmt_ready_i | input | 1 | Memory accepts the commit |
| cmt_addr_o | output | ADDR_W | Commit address |
| cmt_data_o | output | DATA_W | Commit data |
| fence_i | input | 1 | Core requests a fence |
| fence_done_o | output | 1 | Fence may complete (queue empty) |
| count_o | output | $clog2(DEPTH+1) | Number of pending entries |
| empty_o | output | 1 | No pending entries |

## Verification
The load result, the hit and read-enable flags, the fence acknowledge and the commit port are combinational on the present queue contents, so they are due in the same cycle as the stimulus. Count, empty and ready show the effect of a store or commit one clock edge later. The bench drives each stimulus just after the falling edge and samples 1 ns later, before the rising edge that updates the queue. Its reference queue moves only after that edge, so every comparison is made against the contents as they stood at the start of the cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Next slot index with wrap at depth (depth need not be a power of two).
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= PTR_W'(sb_pkg::wrap_inc(32'(wr_q), DEPTH));
      if (pop_i)  rd_q <= PTR_W'(sb_pkg::wrap_inc(32'(rd_q), DEPTH));
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
endmodule

// File: rtl/sb_fwd_search.sv
module sb_fwd_search #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] key_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CNT_W-1:0] age [DEPTH];
  logic [DEPTH-1:0] match;

  // Age = distance from the oldest slot; live when age < count.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign age[g]   = (g >= int'(rd_ptr_i)) ? CNT_W'(g - int'(rd_ptr_i))
                                            : CNT_W'(g + int'(DEPTH) - int'(rd_ptr_i));
    assign match[g] = (age[g] < count_i) && (addr_i[g] == key_i);
  end

  // Youngest match = matching slot with the largest age.
  always_comb begin
    logic [CNT_W-1:0] best;
    hit_o  = 1'b0;
    data_o = '0;
    best   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!hit_o || age[i] > best)) begin
        hit_o  = 1'b1;
        best   = age[i];
        data_o = data_i[i];
      end
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_hit_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              cmt_valid_o,
  input  logic              cmt_ready_i,
  output logic [ADDR_W-1:0] cmt_addr_o,
  output logic [DATA_W-1:0] cmt_data_o,
  input  logic              fence_i,
  output logic              fence_done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              push, pop, full, empty;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;

  assign st_ready_o  = ~full;
  assign cmt_valid_o = ~empty;
  assign push        = st_valid_i & ~full;
  assign pop         = ~empty & cmt_ready_i;

  sb_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .count_o  (count),
    .full_o   (full),
    .empty_o  (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else if (push) begin
      addr_q[wr_ptr] <= st_addr_i;
      data_q[wr_ptr] <= st_data_i;
    end
  end

  // Search sees the contents as of the start of the cycle.
  sb_fwd_search #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_fwd (
    .addr_i   (addr_q),
    .data_i   (data_q),
    .rd_ptr_i (rd_ptr),
    .count_i  (count),
    .key_i    (ld_addr_i),
    .hit_o    (fwd_hit),
    .data_o   (fwd_data)
  );

  assign ld_hit_o     = ld_valid_i & fwd_hit;
  assign mem_re_o     = ld_valid_i & ~fwd_hit;
  assign mem_raddr_o  = ld_addr_i;
  assign ld_data_o    = fwd_hit ? fwd_data : mem_rdata_i;

  assign cmt_addr_o   = addr_q[rd_ptr];
  assign cmt_data_o   = data_q[rd_ptr];

  assign fence_done_o = fence_i & empty;
  assign count_o      = count;
  assign empty_o      = empty;
endmodule

// File: rtl/tso_store_buffer_chk.sv
module tso_store_buffer_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic              st_ready_o,
  input logic              ld_valid_i,
  input logic              ld_hit_o,
  input logic              mem_re_o,
  input logic              cmt_valid_o,
  input logic              cmt_ready_i,
  input logic [ADDR_W-1:0] cmt_addr_o,
  input logic [DATA_W-1:0] cmt_data_o,
  input logic              fence_i,
  input logic              fence_done_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              empty_o
);
  logic acc_st, acc_cmt;
  assign acc_st  = st_valid_i & st_ready_o;
  assign acc_cmt = cmt_valid_o & cmt_ready_i;

  a_r2_store_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_st && empty_o) |-> !cmt_valid_o);

  a_r2_store_visible_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_st && empty_o) |=> cmt_valid_o);

  a_r4_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_W'(DEPTH)) |-> !st_ready_o);

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> count_o == $past(count_o) + CNT_W'($past(acc_st)) - CNT_W'($past(acc_cmt)));

  a_r5_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (count_o == '0));

  a_r7_hit_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hit_o |-> !mem_re_o);

  a_r7_load_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |-> (ld_hit_o != mem_re_o));

  a_r9_fence_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_i && (count_o != '0)) |-> !fence_done_o);

  a_r10_commit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_valid_o && !cmt_ready_i) |=>
      (cmt_valid_o && $stable(cmt_addr_o) && $stable(cmt_data_o)));
endmodule

bind tso_store_buffer tso_store_buffer_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_valid_i   (st_valid_i),
  .st_ready_o   (st_ready_o),
  .ld_valid_i   (ld_valid_i),
  .ld_hit_o     (ld_hit_o),
  .mem_re_o     (mem_re_o),
  .cmt_valid_o  (cmt_valid_o),
  .cmt_ready_i  (cmt_ready_i),
  .cmt_addr_o   (cmt_addr_o),
  .cmt_data_o   (cmt_data_o),
  .fence_i      (fence_i),
  .fence_done_o (fence_done_o),
  .count_o      (count_o),
  .empty_o      (empty_o)
);

// File: tb/tso_store_buffer_tb_top.sv
module tso_store_buffer_tb_top;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // Vector: {op[1:0], ready, addr[7:0], data[31:0]}; op 0 idle, 1 store, 2 load, 3 fence
  localparam int NV = 16;
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'h10, 32'h0000_00A1},
    {2'd1, 1'b0, 8'h20, 32'h0000_00B2},
    {2'd1, 1'b0, 8'h10, 32'h0000_00C3},
    {2'd2, 1'b0, 8'h10, 32'h0},         // youngest of two matches
    {2'd2, 1'b0, 8'h20, 32'h0},
    {2'd2, 1'b0, 8'h30, 32'h0},         // miss -> memory
    {2'd2, 1'b1, 8'h10, 32'h0},         // older 0x10 commits, younger still forwards
    {2'd2, 1'b1, 8'h20, 32'h0},         // load during commit of sole match
    {2'd0, 1'b1, 8'h00, 32'h0},
    {2'd2, 1'b0, 8'h10, 32'h0},         // now from memory
    {2'd3, 1'b0, 8'h00, 32'h0},         // fence on empty
    {2'd1, 1'b0, 8'h40, 32'h0000_00D4},
    {2'd3, 1'b0, 8'h00, 32'h0},         // fence blocked
    {2'd1, 1'b1, 8'h41, 32'h0000_00E5}, // push + pop same cycle
    {2'd3, 1'b1, 8'h00, 32'h0},
    {2'd3, 1'b0, 8'h00, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              st_valid = 1'b0, ld_valid = 1'b0, fence = 1'b0, cmt_ready = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic              st_ready, ld_hit, mem_re, cmt_valid, fence_done, empty;
  logic [DATA_W-1:0] ld_data, mem_rdata, cmt_data;
  logic [ADDR_W-1:0] mem_raddr, cmt_addr;
  logic [CNT_W-1:0]  count;

  logic [DATA_W-1:0] mem_q [256];
  logic [DATA_W-1:0] shadow [256];
  logic [ADDR_W-1:0] q_addr [$];
  logic [DATA_W-1:0] q_data [$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  tso_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr), .st_data_i(st_data),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_data_o(ld_data), .ld_hit_o(ld_hit),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .cmt_valid_o(cmt_valid), .cmt_ready_i(cmt_ready), .cmt_addr_o(cmt_addr), .cmt_data_o(cmt_data),
    .fence_i(fence), .fence_done_o(fence_done), .count_o(count), .empty_o(empty)
  );

  // Memory behind the block
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_q[i] <= 32'h1000_0000 + i;
    end else if (cmt_valid && cmt_ready) begin
      mem_q[cmt_addr] <= cmt_data;
    end
  end
  assign mem_rdata = mem_q[mem_raddr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    q_addr.delete();
    q_data.delete();
    for (int i = 0; i < 256; i++) shadow[i] = 32'h1000_0000 + i;
  endtask

  task automatic cyc(input logic [1:0] op, input logic rdy,
                     input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int sz;
    bit hit, push, pop;
    logic [DATA_W-1:0] exp_ld;
    @(negedge clk);
    st_valid  = (op == 2'd1);
    ld_valid  = (op == 2'd2);
    fence     = (op == 2'd3);
    st_addr   = a;
    ld_addr   = a;
    st_data   = d;
    cmt_ready = rdy;
    #1;
    sz = q_addr.size();
    chk("R5 count", 32'(count), 32'(sz));
    chk("R5 empty", 32'(empty), 32'(sz == 0));
    chk("R4 st_ready", 32'(st_ready), 32'(sz < DEPTH));
    chk("R2 cmt_valid", 32'(cmt_valid), 32'(sz > 0));
    if (sz > 0) begin
      chk("R3 cmt_addr", 32'(cmt_addr), 32'(q_addr[0]));
      chk("R3 cmt_data", cmt_data, q_data[0]);
    end
    if (op == 2'd2) begin
      hit = 1'b0;
      exp_ld = shadow[a];
      for (int j = 0; j < sz; j++) if (q_addr[j] == a) begin hit = 1'b1; exp_ld = q_data[j]; end
      if (hit && rdy && q_addr[0] == a) chk("R8 ld_data on commit", ld_data, exp_ld);
      else if (hit) chk("R6 ld_data youngest", ld_data, exp_ld);
      else chk("R7 ld_data memory", ld_data, exp_ld);
      chk("R6 ld_hit", 32'(ld_hit), 32'(hit));
      chk("R7 mem_re", 32'(mem_re), 32'(!hit));
    end
    chk("R9 fence_done", 32'(fence_done), 32'(fence && sz == 0));
    push = (op == 2'd1) && (sz < DEPTH);
    pop  = rdy && (sz > 0);
    @(posedge clk);
    if (pop) begin
      shadow[q_addr[0]] = q_data[0];
      void'(q_addr.pop_front());
      void'(q_data.pop_front());
    end
    if (push) begin
      q_addr.push_back(a);
      q_data.push_back(d);
    end
  endtask

  task automatic chk_reset_state();
    chk("R1 count", 32'(count), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 cmt_valid", 32'(cmt_valid), 0);
    chk("R1 st_ready", 32'(st_ready), 1);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    #1 chk_reset_state();
    rst_n = 1'b1;
    #1 chk_reset_state();

    for (int v = 0; v < NV; v++)
      cyc(VEC[v][42:41], VEC[v][40], VEC[v][39:32], VEC[v][31:0]);

    // R4: fill to DEPTH; the extra store is dropped
    for (int i = 0; i < DEPTH + 1; i++) cyc(2'd1, 1'b0, 8'h50 + 8'(i), 32'h0000_0F00 + i);
    // Full: store blocked, commit pops
    cyc(2'd1, 1'b1, 8'h70, 32'h0000_0777);
    cyc(2'd2, 1'b0, 8'h58, 32'h0);  // R4: dropped store not forwarded
    cyc(2'd2, 1'b0, 8'h50, 32'h0);  // R7: committed, comes from memory
    // R10: hold stall then drain behind a fence
    cyc(2'd0, 1'b0, 8'h00, 32'h0);
    cyc(2'd0, 1'b0, 8'h00, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) cyc(2'd3, 1'b1, 8'h00, 32'h0);
    cyc(2'd3, 1'b0, 8'h00, 32'h0);  // R9: done once empty

    // R1: asynchronous reset mid-stream
    cyc(2'd1, 1'b0, 8'h90, 32'h0000_0999);
    cyc(2'd1, 1'b0, 8'h91, 32'h0000_0AAA);
    @(negedge clk);
    st_valid = 1'b0; ld_valid = 1'b0; fence = 1'b0; cmt_ready = 1'b0;
    #1 rst_n = 1'b0;
    #1 chk_reset_state();
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(2'd2, 1'b0, 8'h90, 32'h0);  // R7: flushed store gone

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule